// File: doc/BRIEF.md
# Shared-Adder Third-Order Decimator for a 1-Bit Oversampled Stream

This block turns the 1-bit output of a sigma-delta modulator into decimated multi-bit samples using a third-order cascaded integrator-comb (Sinc3) filter. The first integrator adds the incoming bit on every clock, so across each pair of clocks it grows by the pair's sum (0, 1 or 2). The second and third integrators share one adder. One operand of that adder is always the second integrator; the other operand alternates between the first and the third integrator. As a result, the second and third integrators each update on every other clock, at half the bit rate.

Once every decimation period R, a three-stage comb takes successive first differences of the third integrator. The result is right-shifted so that it is right-aligned in a 16-bit output port, and it saturates at the full-scale code. R is chosen as R = 2^k through a small ratio input, which keeps R even as the shared adder requires. The result width is 2k bits and the shift is k−2. A user holds the ratio steady while the block is out of reset, and reads one sample per valid pulse.

Top module: `sinc3_shared_decim`

## Requirements
- R1: While reset is asserted, `valid_o` is 0 and `sample_o` is 0. After reset is released, the first `valid_o` pulse is seen exactly 4·R clocks later, once three periods of comb history have been collected.
- R2: `ratio_log2_i` = k selects R = 2^k, with k legal from 2 to 8. `valid_o` is a single-cycle pulse that recurs exactly every R clocks.
- R3: An all-zero bitstream gives `sample_o` = 0.
- R4: An alternating bitstream (1,0,1,0…, so every pair sums to 1) gives a steady `sample_o` of 2^(2k−1), for example 8 at k=2 and 32768 at k=8.
- R5: An all-ones bitstream reaches 2^(2k) internally and is clamped to 2^(2k)−1 (15, 255 and 65535 for k = 2, 4 and 8). No valid sample ever exceeds 2^(2k)−1.
- R6: A bitstream that repeats every 4 bits with m ones gives a steady `sample_o` of m·2^(2k−2), clamped as in R5. For example, 1,0,0,0 at k=4 gives 64, and 1,1,1,0 at k=8 gives 49152.
- R7: All integrators wrap in two's complement. Steady outputs stay exact over long runs in which the third integrator wraps many times; this is checked over 12 consecutive outputs at R=256.
- R8: The second integrator changes only on clocks where the shared adder feeds it, and the third integrator changes only on the other clocks. The first integrator grows by at most 1 per clock. The filter gain is therefore 2·(R/2)^3 ahead of the k−2 shift.
- R9: After the bit pattern changes, every output from the fifth valid pulse onward equals the new steady level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the bit rate of the stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Modulator bit, one per clock |
| ratio_log2_i | input | 4 | k, where R = 2^k; legal range 2 to 8 |
| sample_o | output | 16 | Decimated result, 2k bits right-aligned, saturated |
| valid_o | output | 1 | One-clock strobe marking a new `sample_o` |

## Verification
The assertions check on every cycle:
- The second and third integrators never change on the same clock, and the first integrator never grows by more than one.
- The valid strobe lasts a single cycle and recurs exactly R clocks apart.
- No valid sample exceeds the full-scale code for the selected k.
- The ratio input stays within its legal range.

Only the bench's scenarios can show the numeric results:
- The DC levels for different bit densities at several ratios.
- The clamp at full scale.
- The exact 4·R delay to the first sample.
- Settling after a pattern change.
- Exactness of the output across many wraps of the third integrator.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // Smallest legal log2 of the decimation ratio; the output shift is k - MIN_LOG2.
  localparam int unsigned MIN_LOG2 = 2;

  // Full-scale code for a 2k-bit right-aligned result.
  function automatic logic [63:0] out_max(input int unsigned k);
    return (64'd1 << (2 * k)) - 64'd1;
  endfunction

  // Align the comb output to 2k bits and clamp at full scale.
  function automatic logic [63:0] scale_sat(input logic [63:0] d3, input int unsigned k);
    logic [63:0] sh;
    sh = d3 >> (k - MIN_LOG2);
    return (sh > out_max(k)) ? out_max(k) : sh;
  endfunction

endpackage

// File: rtl/sinc3_period.sv
module sinc3_period #(
  parameter int unsigned KMAX = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(KMAX+1)-1:0]    ratio_log2,
  output logic                         tick_o,
  output logic                         hist_full_o
);
  import sinc3_pkg::*;

  localparam int unsigned CNT_W = KMAX;
  localparam int unsigned K_W   = $clog2(KMAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_last;
  logic [1:0]       ticks_seen;

  // R-1 as a mask of k low ones.
  assign cnt_last    = ~({CNT_W{1'b1}} << ratio_log2);
  assign tick_o      = (cnt == cnt_last);
  assign hist_full_o = (ticks_seen == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ticks_seen <= '0;
    end else if (tick_o) begin
      cnt <= '0;
      if (ticks_seen != 2'd3) ticks_seen <= ticks_seen + 2'd1;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n) // R2
    (ratio_log2 >= K_W'(MIN_LOG2)) && (ratio_log2 <= K_W'(KMAX)))
    else $error("ratio out of range");

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc3_o
);

  logic             phase;
  logic             upd2_en;
  logic             upd3_en;
  logic [ACC_W-1:0] acc1;
  logic [ACC_W-1:0] acc2;
  logic [ACC_W-1:0] acc3;
  logic [ACC_W-1:0] add_b;
  logic [ACC_W-1:0] add_sum;

  // One adder: acc2 is always an operand, the other side alternates.
  assign upd2_en = ~phase;
  assign upd3_en = phase;
  assign add_b   = phase ? acc3 : acc1;
  assign add_sum = acc2 + add_b;
  assign acc3_o  = acc3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      acc1  <= '0;
      acc2  <= '0;
      acc3  <= '0;
    end else begin
      phase <= ~phase;
      acc1  <= acc1 + ACC_W'(bit_i);
      if (upd2_en) acc2 <= add_sum;
      if (upd3_en) acc3 <= add_sum;
    end
  end

  AST_ACC2_HOLD: assert property (@(posedge clk) disable iff (!rst_n) upd3_en |=> $stable(acc2)) else $error("acc2 moved on acc3 slot"); // R8
  AST_ACC3_HOLD: assert property (@(posedge clk) disable iff (!rst_n) upd2_en |=> $stable(acc3)) else $error("acc3 moved on acc2 slot"); // R8
  AST_ACC1_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((acc1 - $past(acc1)) <= ACC_W'(1))) else $error("acc1 step too large"); // R8

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned KMAX  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic                        hist_full_i,
  input  logic [$clog2(KMAX+1)-1:0]   ratio_log2,
  input  logic [ACC_W-1:0]            acc3_i,
  output logic [2*KMAX-1:0]           sample_o,
  output logic                        valid_o
);
  import sinc3_pkg::*;

  localparam int unsigned OUT_W = 2 * KMAX;

  logic [ACC_W-1:0] z1, z2, z3;
  logic [ACC_W-1:0] d1, d2, d3;

  // Three cascaded first differences across one decimation period.
  assign d1 = acc3_i - z1;
  assign d2 = d1 - z2;
  assign d3 = d2 - z3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z1       <= '0;
      z2       <= '0;
      z3       <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= tick_i && hist_full_i;
      if (tick_i) begin
        z1 <= acc3_i;
        z2 <= d1;
        z3 <= d2;
        if (hist_full_i) sample_o <= OUT_W'(scale_sat(64'(d3), 32'(ratio_log2)));
      end
    end
  end

  // Checker-side spacing counter, independent of the period counter.
  logic [KMAX:0] gap;
  logic [KMAX:0] r_len;
  logic          seen_v;
  assign r_len = (KMAX+1)'(1) << ratio_log2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= '0;
      seen_v <= 1'b0;
    end else begin
      seen_v <= seen_v | valid_o;
      if (valid_o)        gap <= (KMAX+1)'(1);
      else if (gap != '1) gap <= gap + (KMAX+1)'(1);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o) else $error("valid wider than one cycle"); // R2
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && seen_v) |-> (gap == r_len)) else $error("valid spacing"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> (64'(sample_o) <= out_max(32'(ratio_log2)))) else $error("sample above full scale"); // R5

endmodule

// File: rtl/sinc3_shared_decim.sv
module sinc3_shared_decim #(
  parameter int unsigned KMAX = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_i,
  input  logic [$clog2(KMAX+1)-1:0]   ratio_log2_i,
  output logic [2*KMAX-1:0]           sample_o,
  output logic                        valid_o
);

  localparam int unsigned ACC_W = 3 * KMAX;

  logic             tick;
  logic             hist_full;
  logic [ACC_W-1:0] acc3;

  sinc3_period #(.KMAX(KMAX)) period_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_log2  (ratio_log2_i),
    .tick_o      (tick),
    .hist_full_o (hist_full)
  );

  sinc3_integ #(.ACC_W(ACC_W)) integ_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (bit_i),
    .acc3_o (acc3)
  );

  sinc3_comb #(.ACC_W(ACC_W), .KMAX(KMAX)) comb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .hist_full_i (hist_full),
    .ratio_log2  (ratio_log2_i),
    .acc3_i      (acc3),
    .sample_o    (sample_o),
    .valid_o     (valid_o)
  );

endmodule

// File: tb/sinc3_shared_decim_tb_top.sv
module sinc3_shared_decim_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_i = 1'b0;
  logic [3:0]  ratio_log2 = 4'd2;
  logic [15:0] sample_o;
  logic        valid_o;

  always #4 clk = ~clk;  // 125 MHz

  sinc3_shared_decim dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_i        (bit_i),
    .ratio_log2_i (ratio_log2),
    .sample_o     (sample_o),
    .valid_o      (valid_o)
  );

  typedef struct {
    bit          chk;
    int unsigned val;
    string       req;
  } sb_item_t;

  sb_item_t    sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  logic [3:0]  pat = 4'b0000;
  logic [1:0]  pidx = 2'd0;
  longint      cyc = 0;
  longint      last_v = -1;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pattern source: one bit per clock, cycling through a 4-bit pattern.
  always @(negedge clk) begin
    bit_i = pat[pidx];
    pidx  = pidx + 2'd1;
  end

  // Monitor: pop one scoreboard entry per valid strobe.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) last_v = -1;
    else if (valid_o) begin
      if (last_v >= 0) check("R2 spacing", cyc - last_v, longint'(1) << ratio_log2);
      last_v = cyc;
      if (sb_q.size() > 0) begin
        sb_item_t e;
        e = sb_q.pop_front();
        if (e.chk) check(e.req, sample_o, e.val);
      end
    end
  end

  function automatic int unsigned steady(input logic [3:0] p, input int unsigned k);
    int unsigned m, v, mx;
    m  = $countones(p);
    v  = m << (2 * k - 2);
    mx = (1 << (2 * k)) - 1;
    return (v > mx) ? mx : v;
  endfunction

  task automatic push(input logic [3:0] p, input int unsigned nskip,
                      input int unsigned nchk, input string req);
    for (int i = 0; i < int'(nskip); i++) sb_q.push_back('{1'b0, 0, ""});
    for (int i = 0; i < int'(nchk); i++)
      sb_q.push_back('{1'b1, steady(p, ratio_log2), req});
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // Reset with a new ratio, then measure the delay to the first sample (R1).
  task automatic reset_run(input logic [3:0] k, input logic [3:0] p,
                           input int unsigned nchk, input string req);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    ratio_log2 = k;
    pat = p;
    repeat (3) @(negedge clk);
    check("R1 reset valid", valid_o, 0);
    check("R1 reset sample", sample_o, 0);
    push(p, 1, nchk, req);
    rst_n = 1'b1;
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (valid_o) break;
    end
    check("R1 first valid delay", n, 4 * (1 << k));
    drain();
  endtask

  task automatic change(input logic [3:0] p, input int unsigned nchk, input string req);
    pat = p;
    push(p, 4, nchk, req);  // R9: fifth output onward is settled
    drain();
  endtask

  initial begin
    // R = 4
    reset_run(4'd2, 4'b1111, 3, "R5 R2 k=2 full scale");
    change(4'b0101, 3, "R4 R8 R9 k=2 alternating");
    change(4'b0000, 3, "R3 R9 k=2 zeros");
    change(4'b0111, 3, "R6 R9 k=2 three quarters");
    change(4'b0001, 3, "R6 R9 k=2 one quarter");
    // R = 16
    reset_run(4'd4, 4'b1111, 3, "R5 k=4 full scale");
    change(4'b1010, 3, "R4 R8 k=4 alternating");
    change(4'b1000, 3, "R6 k=4 one quarter");
    change(4'b0000, 2, "R3 k=4 zeros");
    // R = 256, long run for wrap-around
    reset_run(4'd8, 4'b1111, 3, "R5 k=8 full scale");
    change(4'b1110, 3, "R6 R9 k=8 three quarters");
    change(4'b0101, 12, "R7 R4 R8 k=8 long alternating");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule